// File: doc/BRIEF.md
# Same-Direction Two-Rate Systolic FIR Convolver

This block computes a 1-D convolution on a linear chain of identical cells. Each cell keeps one coefficient that stays put once loaded. Samples and partial sums both move from cell 0 towards the last cell. A partial sum takes one register per cell. A sample takes two registers per cell, so it moves at half the speed of the sum that is chasing it. As a result, a sum that enters with a given sample meets progressively older samples as it travels. In steady state every cell does a multiply-add on every clock cycle. The block is built for throughput, not for short response time.

Coefficients are written one at a time through a small write port that addresses the cells. The stream side has one qualifier, `in_vld`, which covers both the new sample `x_i` and the seed value `y_i` that starts the sum. A sum leaves the last cell `TAPS` cycles later, flagged by `out_vld`. A cycle with `in_vld` low pushes a zero sample into the chain and creates no result. The chain never stalls.

Top module: `conv_dual_rate`

## Requirements
- R1: While `rst_n` is low, and after reset is released, `out_vld` is 0 and `y_o` is 0. Every coefficient resets to 0, so a result computed before any write equals its seed.
- R2: A cycle with `wt_we` high and `wt_addr` = c < `TAPS` stores `wt_data` as coefficient W[c] of cell c. Cell 0 is the cell that sees the newest sample. The new value applies from the next cycle.
- R3: A coefficient write with `wt_addr` >= `TAPS` changes no coefficient.
- R4: `out_vld` is high exactly `TAPS` rising edges after the edge that captured a cycle with `in_vld` high. Results leave in input order, and no other cycle raises `out_vld`.
- R5: The result for an input taken at stream cycle n equals seed(n) + sum over c in 0..`TAPS`-1 of W[c]·x[n−c]. Here x[m] is the sample accepted at cycle m. Cycles since reset with no sample count as zero.
- R6: When `in_vld` is low, `x_i` and `y_i` are ignored, and a zero sample is shifted into the chain instead.
- R7: Samples, coefficients, seeds and results are signed two's complement. The result wraps modulo 2^`YW`.
- R8: One input can be accepted on every cycle with no gaps. A sample reaches cell c exactly 2c cycles after it enters, and a partial sum reaches cell c exactly c cycles after it enters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wt_we | input | 1 | Coefficient write strobe |
| wt_addr | input | AW | Cell index for the coefficient write |
| wt_data | input | WW | Signed coefficient value |
| in_vld | input | 1 | Qualifies `x_i` and `y_i` this cycle |
| x_i | input | XW | Signed input sample |
| y_i | input | YW | Signed seed for the partial sum |
| out_vld | output | 1 | `y_o` carries a finished result |
| y_o | output | YW | Signed convolution result |

## Verification
The hardest condition to reach is one where the half-speed sample stream and the full-speed sum stream disagree about what happened during an idle cycle. The stimulus creates this by mixing back-to-back bursts with alternating gaps, and it drives large non-zero samples during the gap cycles. If those samples leak in, or if the zero injection is misaligned, the next results come out wrong. Wraparound is reached by using the most positive seed together with a positive product, and by using the most negative samples and coefficients together. Out-of-range coefficient writes are issued between bursts, and the following results show whether any coefficient moved.

// File: rtl/ds_pkg.sv
package ds_pkg;
    // Width of a cell index for a chain of n cells.
    function automatic int sel_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/ds_wdec.sv
module ds_wdec #(
    parameter int TAPS = 3,
    parameter int AW   = 2
) (
    input  logic            we_i,
    input  logic [AW-1:0]   addr_i,
    output logic [TAPS-1:0] we_o
);
    for (genvar c = 0; c < TAPS; c++) begin : g_sel
        assign we_o[c] = we_i && (addr_i == AW'(c));
    end

    always_comb begin
        if (!$isunknown({we_i, addr_i})) begin
            AST_WE_ONEHOT: assert ($onehot0(we_o)); // R2
            if (32'(addr_i) >= TAPS)
                AST_WE_RANGE: assert (we_o == '0); // R3
        end
    end
endmodule

// File: rtl/ds_cell.sv
module ds_cell #(
    parameter int XW = 8,
    parameter int WW = 8,
    parameter int YW = 19
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 w_we,
    input  logic signed [WW-1:0] w_data,
    input  logic signed [XW-1:0] x_in,
    input  logic signed [YW-1:0] y_in,
    input  logic                 v_in,
    output logic signed [XW-1:0] x_out,
    output logic signed [YW-1:0] y_out,
    output logic                 v_out
);
    localparam int PW = XW + WW;

    typedef struct packed {
        logic [WW-1:0] w;
        logic [XW-1:0] xm;
        logic [XW-1:0] xo;
        logic [YW-1:0] y;
        logic          v;
    } cell_t;

    cell_t s_d, s_q;
    logic signed [PW-1:0] prod;
    logic signed [YW-1:0] prod_ext;

    always_comb begin
        prod     = PW'(x_in) * PW'($signed(s_q.w));
        prod_ext = YW'(prod);
        s_d      = s_q;
        if (w_we)
            s_d.w = w_data;
        s_d.xm = x_in;
        s_d.xo = s_q.xm;
        s_d.y  = y_in + prod_ext;
        s_d.v  = v_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign x_out = $signed(s_q.xo);
    assign y_out = $signed(s_q.y);
    assign v_out = s_q.v;

    // Cycles since reset, saturating, for the assertions below.
    logic [1:0] age_d, age_q;
    always_comb age_d = (age_q == 2'd2) ? age_q : age_q + 2'd1;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) age_q <= '0;
        else        age_q <= age_d;
    end

    AST_X_TWO_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd2) |-> (x_out == $past(x_in, 2))); // R8

    AST_W_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ((age_q != 2'd0) && !$past(w_we)) |-> $stable(s_q.w)); // R3
endmodule

// File: rtl/conv_dual_rate.sv
module conv_dual_rate #(
    parameter int TAPS = 3,
    parameter int XW   = 8,
    parameter int WW   = 8,
    parameter int YW   = XW + WW + $clog2(TAPS) + 1,
    parameter int AW   = ds_pkg::sel_w(TAPS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wt_we,
    input  logic [AW-1:0]        wt_addr,
    input  logic signed [WW-1:0] wt_data,
    input  logic                 in_vld,
    input  logic signed [XW-1:0] x_i,
    input  logic signed [YW-1:0] y_i,
    output logic                 out_vld,
    output logic signed [YW-1:0] y_o
);
    logic [TAPS-1:0]      cell_we;
    logic signed [XW-1:0] xc [TAPS+1];
    logic signed [YW-1:0] yc [TAPS+1];
    logic                 vc [TAPS+1];

    ds_wdec #(.TAPS(TAPS), .AW(AW)) u_wdec (
        .we_i   (wt_we),
        .addr_i (wt_addr),
        .we_o   (cell_we)
    );

    // Idle cycles shift a zero sample into the chain.
    assign xc[0] = in_vld ? x_i : '0;
    assign yc[0] = y_i;
    assign vc[0] = in_vld;

    for (genvar c = 0; c < TAPS; c++) begin : g_cell
        ds_cell #(.XW(XW), .WW(WW), .YW(YW)) u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .w_we   (cell_we[c]),
            .w_data (wt_data),
            .x_in   (xc[c]),
            .y_in   (yc[c]),
            .v_in   (vc[c]),
            .x_out  (xc[c+1]),
            .y_out  (yc[c+1]),
            .v_out  (vc[c+1])
        );
    end

    assign y_o     = yc[TAPS];
    assign out_vld = vc[TAPS];

    // Independent history of accepted inputs for the latency check.
    logic [TAPS-1:0] vh_d, vh_q;
    always_comb begin
        vh_d = vh_q << 1;
        vh_d[0] = in_vld;
    end
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) vh_q <= '0;
        else        vh_q <= vh_d;
    end

    AST_OUT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld == vh_q[TAPS-1]); // R4

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (vh_q == '0) |-> !out_vld); // R1
endmodule

// File: tb/sim_conv_dual_rate.sv
`timescale 1ns/1ps
module sim_conv_dual_rate;
    localparam int TAPS = 3;
    localparam int XW   = 8;
    localparam int WW   = 8;
    localparam int YW   = XW + WW + $clog2(TAPS) + 1;
    localparam int AW   = ds_pkg::sel_w(TAPS);

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 wt_we = 1'b0;
    logic [AW-1:0]        wt_addr = '0;
    logic signed [WW-1:0] wt_data = '0;
    logic                 in_vld = 1'b0;
    logic signed [XW-1:0] x_i = '0;
    logic signed [YW-1:0] y_i = '0;
    logic                 out_vld;
    logic signed [YW-1:0] y_o;

    conv_dual_rate #(.TAPS(TAPS), .XW(XW), .WW(WW)) u0 (
        .clk(clk), .rst_n(rst_n), .wt_we(wt_we), .wt_addr(wt_addr),
        .wt_data(wt_data), .in_vld(in_vld), .x_i(x_i), .y_i(y_i),
        .out_vld(out_vld), .y_o(y_o)
    );

    always #4 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit started = 1'b0;
    bit done = 1'b0;

    typedef struct {
        logic [YW-1:0] exp;
        int            due;
        string         tag;
    } item_t;
    item_t sb[$];

    longint w_m [TAPS];
    longint xh  [TAPS];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic step(input bit v, input longint x, input longint seed, input string tag);
        item_t it;
        longint s;
        in_vld = v;
        x_i    = XW'(x);
        y_i    = YW'(seed);
        for (int c = TAPS - 1; c > 0; c--) xh[c] = xh[c-1];
        xh[0] = v ? x : 0;
        if (v) begin
            s = seed;
            for (int c = 0; c < TAPS; c++) s += w_m[c] * xh[c];
            it.exp = YW'(s);
            it.due = cyc + TAPS;
            it.tag = tag;
            sb.push_back(it);
        end
        @(negedge clk);
        in_vld = 1'b0;
    endtask

    task automatic wr(input int a, input longint d);
        wt_we   = 1'b1;
        wt_addr = AW'(a);
        wt_data = WW'(d);
        if (a < TAPS) w_m[a] = d;
        step(1'b0, 0, 0, "R2");
        wt_we = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 77, 5, "R6");
    endtask

    // Scoreboard monitor.
    always @(negedge clk) begin
        if (started && rst_n) begin
            if (sb.size() != 0 && sb[0].due < cyc) begin
                chk(1'b0, "R4", "missing result at cycle", cyc, sb[0].due);
                void'(sb.pop_front());
            end
            if (out_vld) begin
                if (sb.size() == 0) begin
                    chk(1'b0, "R4", "unexpected out_vld, queue size", 0, 1);
                end else begin
                    item_t it;
                    it = sb.pop_front();
                    chk(cyc == it.due, "R4", "result cycle", cyc, it.due);
                    chk(y_o == $signed(it.exp), it.tag, "result value",
                        longint'(y_o), longint'($signed(it.exp)));
                end
            end
        end
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            errors++;
            $display("FAIL R4 watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < TAPS; c++) begin w_m[c] = 0; xh[c] = 0; end
        repeat (3) @(negedge clk);
        chk(out_vld == 1'b0, "R1", "out_vld in reset", out_vld, 0);
        chk(y_o == '0, "R1", "y_o in reset", y_o, 0);
        rst_n = 1'b1;
        started = 1'b1;
        @(negedge clk);
        chk(out_vld == 1'b0, "R1", "out_vld after reset", out_vld, 0);
        chk(y_o == '0, "R1", "y_o after reset", y_o, 0);

        // R1: zero coefficients, result equals seed.
        for (int i = 0; i < 4; i++) step(1'b1, 10 + i, 100 * i - 150, "R1");
        idle(TAPS + 1);

        // R2: load coefficients, then stream.
        wr(0, 2); wr(1, -3); wr(2, 5);
        idle(2);
        for (int i = 0; i < 12; i++) step(1'b1, i * 7 - 20, i * 3, "R8");
        idle(TAPS + 1);
        wr(1, 4);
        idle(2);
        for (int i = 0; i < 6; i++) step(1'b1, 50 - i * 17, -i, "R5");
        idle(TAPS + 1);

        // R3: out-of-range write leaves coefficients untouched.
        wr(3, 77);
        idle(2);
        for (int i = 0; i < 5; i++) step(1'b1, i + 1, 0, "R3");
        idle(TAPS + 1);

        // R6: gaps with large samples on the idle cycles.
        for (int i = 0; i < 10; i++) begin
            step(1'b1, i * 11 - 40, 7, "R6");
            step(1'b0, 127, 9999, "R6");
        end
        idle(TAPS + 1);

        // R7: signed extremes and wrap.
        wr(0, 1); wr(1, 0); wr(2, 0);
        idle(2);
        step(1'b1, 1, (longint'(1) << (YW - 1)) - 1, "R7");
        step(1'b1, -1, -(longint'(1) << (YW - 1)), "R7");
        idle(TAPS + 1);
        wr(0, -128); wr(1, -128); wr(2, -128);
        idle(2);
        for (int i = 0; i < 4; i++) step(1'b1, -128, 0, "R7");
        step(1'b1, 127, -(longint'(1) << (YW - 1)), "R7");
        idle(TAPS + 2);

        chk(sb.size() == 0, "R4", "results left outstanding", sb.size(), 0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule